// File: doc/BRIEF.md
# Butterfly Pairwise Barrier Engine

This block sits beside one processing node in a group of `NODES` nodes (a power of two) and runs a symmetric, single-phase barrier. When the core raises a barrier request, the engine works through `log2(NODES)` stages. In stage `s` it sends one notification to the node whose id differs from its own only in bit `s`, and it waits for that same node's stage-`s` notification. Once both halves of the exchange are complete, it moves to the next stage. After the last exchange it gives the core a one-cycle completion pulse. No node acts as master. The whole group costs `NODES*log2(NODES)` messages per barrier.

Messages leave through a valid/ready send port that carries the destination, the source id and the stage number. They arrive through a receive port that carries the source id and the stage number. A partner may be ahead of this node, so a message for a later stage, or for stage 0 while this node is still idle, is recorded in a per-stage arrival flag. Such a message is kept, never dropped. A flag is cleared when its stage is used, so nothing carries over into the next barrier except messages that really belong to it. Routing and packet formatting are outside this block.

Top module: `bfly_barrier_node`

## Requirements
- R1: While a stage-`s` message is offered, `tx_dst` equals `node_id XOR (1<<s)`, `tx_src` equals `node_id`, and `tx_stage` equals `s`. Stage numbering starts at 0, and stage 0 flips bit 0 of the id.
- R2: In one barrier, exactly one message is sent for each stage, in the order 0, 1, … `log2(NODES)-1`. A message is sent in the cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_valid` and `tx_stage` hold.
- R3: A node leaves stage `s` only after its stage-`s` send has been accepted and its partner's stage-`s` message has been recorded. A received message is recorded at the edge where it is presented. The advance can happen at the following edge at the earliest. When the partner message is presented in the acceptance cycle, each stage takes 2 cycles. When it is presented the cycle after acceptance, each stage takes 3 cycles.
- R4: A partner message that arrives before its stage is reached is kept. This holds for any stage and also while the node is idle.
- R5: A received message is ignored if its source is not the partner for its stated stage, or if its stage number is `log2(NODES)` or more.
- R6: `bar_done` is high for exactly one cycle. That cycle follows the edge at which the last stage is left. The engine is then idle and offers no message.
- R7: Leaving a stage clears that stage's flag. After a barrier completes, a new request with no new messages sends its stage-0 message and then waits; `bar_done` does not rise.
- R8: A partner message presented at the same edge that consumes the flag for its stage sets that flag again. The message counts for the next barrier.
- R9: `bar_req` while a barrier is in progress has no effect on the stage sequence, the latency or the number of completions.
- R10: After reset, `bar_done` and `tx_valid` are low, and no arrival flag is set.
- R11: If every partner message is already recorded and `tx_ready` stays high, `bar_done` rises `log2(NODES)` cycles after the edge that samples `bar_req`. If `tx_ready` is held low for `W` cycles at each stage, the time is `(W+1)*log2(NODES)` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | ID_W | This node's id, 0..NODES-1 |
| bar_req | input | 1 | Core enters the barrier (sampled while idle) |
| bar_done | output | 1 | One-cycle completion pulse |
| tx_valid | output | 1 | A notification is offered |
| tx_ready | input | 1 | Network takes the offered notification |
| tx_dst | output | ID_W | Destination node id |
| tx_src | output | ID_W | Source id carried in the message |
| tx_stage | output | STG_W | Stage number carried in the message |
| rx_valid | input | 1 | A notification arrives this cycle |
| rx_src | input | ID_W | Sender id of the arriving notification |
| rx_stage | input | STG_W | Stage number of the arriving notification |

## Verification
Two events can land in the same cycle. The first pair is the acceptance of this node's own send and the arrival of the partner's message for the same stage. The bench provokes this by presenting the partner message in the acceptance cycle, and it judges the result by an exact 2-cycle-per-stage completion time. The second pair is the consumption of the stage-0 flag and a fresh stage-0 message meant for the next barrier. The bench presents that message at the consuming edge. It then starts a second barrier with only stages 1 and upward supplied, which must finish in the minimum time. The bench sweeps every node id of an 8-node group through these cases and the other arrival orderings.

// File: rtl/bfly_pkg.sv
`timescale 1ns/1ps
package bfly_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Partner of a node at a given stage: flip exactly one id bit.
    function automatic logic [31:0] peer_of(input logic [31:0] id, input int unsigned stg);
        return id ^ (32'd1 << stg);
    endfunction

    // Stage-field width; at least one bit.
    function automatic int unsigned stage_width(input int unsigned stages);
        return (stages > 1) ? $clog2(stages) : 1;
    endfunction

endpackage

// File: rtl/bfly_peer_map.sv
`timescale 1ns/1ps
module bfly_peer_map
    import bfly_pkg::*;
#(
    parameter int unsigned ID_W   = 3,
    parameter int unsigned STAGES = 3,
    parameter int unsigned STG_W  = 2
) (
    input  logic [ID_W-1:0]   node_id,
    input  logic [STG_W-1:0]  cur_stage,
    input  logic              rx_valid,
    input  logic [ID_W-1:0]   rx_src,
    input  logic [STG_W-1:0]  rx_stage,
    output logic [ID_W-1:0]   tx_dst,
    output logic [STAGES-1:0] hit
);

    assign tx_dst = ID_W'(peer_of(32'(node_id), 32'(cur_stage)));

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [ID_W-1:0] expect_src;
        assign expect_src = ID_W'(peer_of(32'(node_id), i));
        assign hit[i] = rx_valid
                     && (rx_stage == STG_W'(i))
                     && (rx_src == expect_src);
    end

endmodule

// File: rtl/bfly_arrival_flags.sv
`timescale 1ns/1ps
module bfly_arrival_flags #(
    parameter int unsigned STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] hit,
    input  logic [STAGES-1:0] consume,
    output logic [STAGES-1:0] arrived
);

    for (genvar i = 0; i < STAGES; i++) begin : g_flag
        logic flag_q;

        // A new arrival wins over consumption in the same cycle.
        always_ff @(posedge clk) begin
            if (rst) flag_q <= 1'b0;
            else     flag_q <= hit[i] | (flag_q & ~consume[i]);
        end

        assign arrived[i] = flag_q;

        AST_ARRIVAL_KEPT: assert property (@(posedge clk) disable iff (rst)
            hit[i] |=> arrived[i]); // R8

        AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (rst)
            $rose(arrived[i]) |-> $past(hit[i])); // R5

        AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
            (consume[i] && !hit[i]) |=> !arrived[i]); // R7
    end

endmodule

// File: rtl/bfly_stage_seq.sv
`timescale 1ns/1ps
module bfly_stage_seq
    import bfly_pkg::*;
#(
    parameter int unsigned STAGES = 3,
    parameter int unsigned STG_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bar_req,
    input  logic              tx_ready,
    input  logic [STAGES-1:0] arrived,
    output logic              tx_valid,
    output logic [STG_W-1:0]  cur_stage,
    output logic [STAGES-1:0] consume,
    output logic              bar_done
);

    localparam logic [STG_W-1:0] LAST_STG = STG_W'(STAGES - 1);

    seq_state_e       state_q;
    logic [STG_W-1:0] stage_q;
    logic             sent_q;
    logic             done_q;
    logic             tx_fire;
    logic             sent_eff;
    logic             cur_arrived;
    logic             adv;

    assign tx_valid    = (state_q == SEQ_RUN) && !sent_q;
    assign tx_fire     = tx_valid && tx_ready;
    assign sent_eff    = sent_q || tx_fire;
    assign cur_arrived = arrived[stage_q];
    assign adv         = (state_q == SEQ_RUN) && sent_eff && cur_arrived;
    assign cur_stage   = stage_q;
    assign bar_done    = done_q;

    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            consume[i] = adv && (stage_q == STG_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            stage_q <= '0;
            sent_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (bar_req) begin
                        state_q <= SEQ_RUN;
                        stage_q <= '0;
                        sent_q  <= 1'b0;
                    end
                end
                SEQ_RUN: begin
                    if (adv) begin
                        sent_q <= 1'b0;
                        if (stage_q == LAST_STG) begin
                            state_q <= SEQ_IDLE;
                            stage_q <= '0;
                            done_q  <= 1'b1;
                        end else begin
                            stage_q <= stage_q + STG_W'(1);
                        end
                    end else if (tx_fire) begin
                        sent_q <= 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        bar_done |=> !bar_done); // R6

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        bar_done |-> !tx_valid); // R6

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(cur_stage))); // R2

    AST_STAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == SEQ_RUN && state_q == SEQ_RUN && cur_stage != $past(cur_stage))
        |-> (cur_stage == $past(cur_stage) + STG_W'(1))); // R2

    AST_ADV_NEEDS_PEER: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == SEQ_RUN && (state_q == SEQ_IDLE || cur_stage != $past(cur_stage)))
        |-> $past(cur_arrived)); // R3

    AST_ADV_NEEDS_SEND: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == SEQ_RUN && (state_q == SEQ_IDLE || cur_stage != $past(cur_stage)))
        |-> $past(sent_q || (tx_valid && tx_ready))); // R3

    AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RUN && !arrived[stage_q]) |=> (state_q == SEQ_RUN && $stable(cur_stage))); // R9

endmodule

// File: rtl/bfly_barrier_node.sv
`timescale 1ns/1ps
module bfly_barrier_node
    import bfly_pkg::*;
#(
    parameter int unsigned NODES  = 8,
    parameter int unsigned ID_W   = $clog2(NODES),
    parameter int unsigned STAGES = $clog2(NODES),
    parameter int unsigned STG_W  = stage_width(STAGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ID_W-1:0]  node_id,
    input  logic             bar_req,
    output logic             bar_done,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [ID_W-1:0]  tx_dst,
    output logic [ID_W-1:0]  tx_src,
    output logic [STG_W-1:0] tx_stage,
    input  logic             rx_valid,
    input  logic [ID_W-1:0]  rx_src,
    input  logic [STG_W-1:0] rx_stage
);

    logic [STAGES-1:0] hit;
    logic [STAGES-1:0] consume;
    logic [STAGES-1:0] arrived;
    logic [STG_W-1:0]  cur_stage;

    initial begin
        if (NODES < 2 || (NODES & (NODES - 1)) != 0)
            $error("NODES must be a power of two, at least 2");
    end

    bfly_peer_map #(
        .ID_W   (ID_W),
        .STAGES (STAGES),
        .STG_W  (STG_W)
    ) u_peer (
        .node_id   (node_id),
        .cur_stage (cur_stage),
        .rx_valid  (rx_valid),
        .rx_src    (rx_src),
        .rx_stage  (rx_stage),
        .tx_dst    (tx_dst),
        .hit       (hit)
    );

    bfly_arrival_flags #(
        .STAGES (STAGES)
    ) u_flags (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .consume (consume),
        .arrived (arrived)
    );

    bfly_stage_seq #(
        .STAGES (STAGES),
        .STG_W  (STG_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .bar_req   (bar_req),
        .tx_ready  (tx_ready),
        .arrived   (arrived),
        .tx_valid  (tx_valid),
        .cur_stage (cur_stage),
        .consume   (consume),
        .bar_done  (bar_done)
    );

    assign tx_src   = node_id;
    assign tx_stage = cur_stage;

    AST_DST_DIFFERS_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> ($countones(tx_dst ^ node_id) == 1)); // R1

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!bar_done && !tx_valid)); // R10

endmodule

// File: tb/sim_bfly_barrier_node.sv
`timescale 1ns/1ps
module sim_bfly_barrier_node;

    localparam int NODES = 8;
    localparam int ID_W  = 3;
    localparam int S     = 3;
    localparam int STG_W = 2;

    localparam int M_PRE   = 0;
    localparam int M_SAME  = 1;
    localparam int M_LAZY  = 2;
    localparam int M_STALL = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [ID_W-1:0]  node_id = '0;
    logic             bar_req = 1'b0;
    logic             bar_done;
    logic             tx_valid;
    logic             tx_ready = 1'b0;
    logic [ID_W-1:0]  tx_dst;
    logic [ID_W-1:0]  tx_src;
    logic [STG_W-1:0] tx_stage;
    logic             rx_valid = 1'b0;
    logic [ID_W-1:0]  rx_src = '0;
    logic [STG_W-1:0] rx_stage = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bfly_barrier_node #(.NODES(NODES)) u0 (
        .clk(clk), .rst(rst), .node_id(node_id),
        .bar_req(bar_req), .bar_done(bar_done),
        .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_dst(tx_dst), .tx_src(tx_src), .tx_stage(tx_stage),
        .rx_valid(rx_valid), .rx_src(rx_src), .rx_stage(rx_stage)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; bar_req = 1'b0; rx_valid = 1'b0; tx_ready = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic present(input int id, input int s);
        rx_valid = 1'b1;
        rx_src   = ID_W'(id ^ (1 << s));
        rx_stage = STG_W'(s);
    endtask

    // Returns latency in edges after the request edge (-1 on no completion)
    // and the number of stage messages accepted.
    task automatic run_barrier(input int id, input int mode, input int waitc,
                               input int premask, input bit extra0, input bit dup_req,
                               input int limit, output int lat, output int sent);
        int es; int stall; int pend; int n;
        node_id = ID_W'(id);
        for (int s = 0; s < S; s++) begin
            if (premask[s]) begin present(id, s); tick(); end
        end
        rx_valid = 1'b0;
        bar_req = 1'b1; tick(); bar_req = 1'b0;
        es = 0; stall = 0; pend = -1; lat = -1; n = 0;
        while (n < limit) begin
            if (bar_done) begin lat = n; break; end
            rx_valid = 1'b0;
            bar_req  = (dup_req && n == 1);
            if (pend >= 0) begin present(id, pend); pend = -1; end
            if (extra0 && n == 0) present(id, 0);
            if (mode == M_STALL && stall < waitc) begin
                tx_ready = 1'b0; stall++;
            end else begin
                tx_ready = 1'b1;
            end
            if (tx_valid && tx_ready) begin
                chk(tx_dst == ID_W'(id ^ (1 << es)), "R1 dst", int'(tx_dst), id ^ (1 << es));
                chk(tx_src == ID_W'(id), "R1 src", int'(tx_src), id);
                chk(int'(tx_stage) == es, "R2 order", int'(tx_stage), es);
                if (mode == M_SAME) present(id, es);
                if (mode == M_LAZY) pend = es;
                es++; stall = 0;
            end
            tick(); n++;
        end
        rx_valid = 1'b0; bar_req = 1'b0; tx_ready = 1'b1;
        sent = es;
        if (lat >= 0) begin
            tick();
            chk(!bar_done, "R6 single pulse", int'(bar_done), 0);
            chk(!tx_valid, "R9 no restart", int'(tx_valid), 0);
        end
    endtask

    initial begin
        int lat; int sent;
        do_reset();
        chk(!bar_done, "R10 done", int'(bar_done), 0);
        chk(!tx_valid, "R10 tx_valid", int'(tx_valid), 0);

        // R10: fresh flags — a request right after reset must wait after stage 0
        run_barrier(5, M_PRE, 0, 0, 1'b0, 1'b0, 20, lat, sent);
        chk(lat == -1, "R10 no stale flag", lat, -1);
        chk(sent == 1, "R10 stage0 only", sent, 1);
        do_reset();

        for (int id = 0; id < NODES; id++) begin
            // R4/R11: all arrivals early (while idle)
            run_barrier(id, M_PRE, 0, 7, 1'b0, 1'b0, 60, lat, sent);
            chk(lat == S, "R11 preloaded latency", lat, S);
            chk(sent == S, "R2 message count", sent, S);
            chk(lat == S, "R4 early kept", lat, S);

            // R3: partner message coincides with acceptance
            run_barrier(id, M_SAME, 0, 0, 1'b0, 1'b0, 60, lat, sent);
            chk(lat == 2 * S, "R3 same-cycle", lat, 2 * S);

            // R3: partner message one cycle after acceptance
            run_barrier(id, M_LAZY, 0, 0, 1'b0, 1'b0, 60, lat, sent);
            chk(lat == 3 * S, "R3 late partner", lat, 3 * S);

            // R2/R11: back-pressure of 2 cycles per stage
            run_barrier(id, M_STALL, 2, 7, 1'b0, 1'b0, 60, lat, sent);
            chk(lat == 3 * S, "R11 stalled latency", lat, 3 * S);
            chk(sent == S, "R2 stalled count", sent, S);

            // R9: duplicate request while busy
            run_barrier(id, M_PRE, 0, 7, 1'b0, 1'b1, 60, lat, sent);
            chk(lat == S, "R9 busy request", lat, S);

            // R8: new stage-0 message at the consuming edge carries over
            run_barrier(id, M_PRE, 0, 7, 1'b1, 1'b0, 60, lat, sent);
            chk(lat == S, "R8 first barrier", lat, S);
            run_barrier(id, M_PRE, 0, 6, 1'b0, 1'b0, 60, lat, sent);
            chk(lat == S, "R8 carried stage0", lat, S);

            // R7: completed barrier leaves no flags behind
            run_barrier(id, M_PRE, 0, 0, 1'b0, 1'b0, 20, lat, sent);
            chk(lat == -1, "R7 no leftover", lat, -1);
            chk(sent == 1, "R7 waits after stage0", sent, 1);
            do_reset();

            // R5: wrong partner, wrong stage pairing, out-of-range stage
            node_id = ID_W'(id);
            rx_valid = 1'b1; rx_src = ID_W'(id ^ 2); rx_stage = 2'd0; tick();
            rx_src = ID_W'(id ^ 1); rx_stage = 2'd3; tick();
            rx_src = ID_W'(id ^ 4); rx_stage = 2'd0; tick();
            rx_valid = 1'b0;
            run_barrier(id, M_PRE, 0, 0, 1'b0, 1'b0, 20, lat, sent);
            chk(lat == -1, "R5 ignored sources", lat, -1);
            chk(sent == 1, "R5 held at stage0", sent, 1);
            do_reset();
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule